// File: doc/BRIEF.md
# Predicated Vector Splice Unit

This datapath block merges two vector operands into one result under a byte-granular predicate mask. The first and last active lanes of the predicate, for the selected element size, mark a contiguous window in operand A. That window is packed into the result starting at lane 0. The rest of the result is then filled from operand B, starting at B's lane 0.

The element size is chosen per operation by a 2-bit code. The result is registered and appears one clock after a start strobe, together with a one-cycle valid pulse. The block has no flags output. It does not choose where the result is written: a destructive or constructive write target is decided by the logic around it.

Top module: `splice_unit`

## Requirements
- R1: The element width is 8 << size_i bits: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The lane count is VEC_W divided by the element width, and lane n occupies bits [n*width +: width].
- R2: A lane is active exactly when predicate bit lane*(width/8) is set. Every other predicate bit has no effect on the result.
- R3: The lanes of opa_i from the lowest active lane to the highest active lane, inclusive, are written in order to result lanes 0, 1, 2 and upward.
- R4: Lanes lying between the first and last active lanes are copied even when their own predicate bit is clear.
- R5: After the copied window, the remaining result lanes take opb_i lanes 0, 1, 2 and upward, in order.
- R6: When no lane is active, the result equals opb_i.
- R7: valid_o is high in the cycle after every cycle in which start_i is high, and low after every cycle in which start_i is low.
- R8: res_o keeps its value through any cycle in which start_i is low, whatever the other inputs do.
- R9: While rst_ni is low, valid_o and res_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation with the operands of this cycle |
| size_i | input | 2 | Element size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| pred_i | input | VEC_W/8 | Predicate, one bit per byte of the vector |
| opa_i | input | VEC_W | First operand, source of the packed window |
| opb_i | input | VEC_W | Second operand, source of the fill lanes |
| res_o | output | VEC_W | Registered result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The case that needs care is a new start arriving in the same cycle as the previous result is presented. The register must then replace that result while valid stays high, and neither the window nor the fill may carry over from the earlier operation. The bench provokes this with a long run of back-to-back starts, each with random operands, size and predicate density. It checks every result against a lane-by-lane reference one cycle after its own start. Directed idle cycles in between confirm that the valid pulse drops and that the result holds while the inputs change.

// File: rtl/splice_pkg.sv
package splice_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned NUM_ESZ = 4;

endpackage

// File: rtl/splice_pred_scan.sv
module splice_pred_scan
  import splice_pkg::*;
#(
  parameter int unsigned NB = 32
) (
  input  logic [1:0]               size_i,
  input  logic [NB-1:0]            pred_i,
  output logic                     any_o,
  output logic [$clog2(NB)-1:0]    first_o,
  output logic [$clog2(NB+1)-1:0]  span_o
);
  localparam int unsigned IDX_W = $clog2(NB);
  localparam int unsigned CNT_W = $clog2(NB+1);

  // lane-leading byte masks, one per element size
  logic [NB-1:0] lead_mask [NUM_ESZ];
  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_mask
    for (genvar k = 0; k < NB; k++) begin : g_bit
      assign lead_mask[g][k] = ((k % (1 << g)) == 0);
    end
  end

  logic [NB-1:0]    act;
  logic [IDX_W-1:0] first_byte;
  logic [IDX_W-1:0] last_byte;
  logic [CNT_W-1:0] lane_bytes;

  assign act        = pred_i & lead_mask[size_i];
  assign any_o      = |act;
  assign lane_bytes = CNT_W'(1) << size_i;

  always_comb begin
    first_byte = '0;
    for (int k = NB-1; k >= 0; k--) begin
      if (act[k]) first_byte = IDX_W'(k);
    end
  end

  always_comb begin
    last_byte = '0;
    for (int k = 0; k < NB; k++) begin
      if (act[k]) last_byte = IDX_W'(k);
    end
  end

  assign first_o = first_byte;
  assign span_o  = any_o ? (CNT_W'(last_byte) - CNT_W'(first_byte) + lane_bytes) : '0;

  always_comb begin
    if (any_o && !$isunknown(pred_i)) begin
      p_first_aligned_r2: assert ((CNT_W'(first_byte) & (lane_bytes - CNT_W'(1))) == '0)
        else $error("window start not lane aligned");
      p_span_bound_r3: assert (((CNT_W+1)'(first_byte) + (CNT_W+1)'(span_o)) <= (CNT_W+1)'(NB))
        else $error("window exceeds vector");
    end
  end

endmodule

// File: rtl/splice_byte_xbar.sv
module splice_byte_xbar #(
  parameter int unsigned NB = 32
) (
  input  logic [NB*8-1:0]          opa_i,
  input  logic [NB*8-1:0]          opb_i,
  input  logic [$clog2(NB)-1:0]    first_i,
  input  logic [$clog2(NB+1)-1:0]  span_i,
  output logic [NB*8-1:0]          res_o
);
  localparam int unsigned IDX_W = $clog2(NB);
  localparam int unsigned CNT_W = $clog2(NB+1);

  logic [7:0] a_byte [NB];
  logic [7:0] b_byte [NB];

  for (genvar k = 0; k < NB; k++) begin : g_split
    assign a_byte[k] = opa_i[k*8 +: 8];
    assign b_byte[k] = opb_i[k*8 +: 8];
  end

  // output byte k: window byte first+k, else fill byte k-span
  for (genvar k = 0; k < NB; k++) begin : g_out
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;
    assign a_idx = first_i + IDX_W'(k);
    assign b_idx = IDX_W'(k) - span_i[IDX_W-1:0];
    assign res_o[k*8 +: 8] = (CNT_W'(k) < span_i) ? a_byte[a_idx] : b_byte[b_idx];
  end

endmodule

// File: rtl/splice_unit.sv
module splice_unit
  import splice_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           size_i,
  input  logic [VEC_W/8-1:0]   pred_i,
  input  logic [VEC_W-1:0]     opa_i,
  input  logic [VEC_W-1:0]     opb_i,
  output logic [VEC_W-1:0]     res_o,
  output logic                 valid_o
);
  localparam int unsigned NB    = VEC_W / 8;
  localparam int unsigned IDX_W = $clog2(NB);
  localparam int unsigned CNT_W = $clog2(NB+1);

  logic             any;
  logic [IDX_W-1:0] first;
  logic [CNT_W-1:0] span;
  logic [VEC_W-1:0] res_d;
  logic [7:0]       head_byte;

  splice_pred_scan #(.NB(NB)) u_scan (
    .size_i  (size_i),
    .pred_i  (pred_i),
    .any_o   (any),
    .first_o (first),
    .span_o  (span)
  );

  splice_byte_xbar #(.NB(NB)) u_xbar (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .first_i (first),
    .span_i  (span),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) res_o <= res_d;
    end
  end

  assign head_byte = opa_i[first*8 +: 8];

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o) else $error("valid missing after start");

  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o) else $error("valid without start");

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(res_o)) else $error("result changed while idle");

  p_empty_pred_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !any) |=> (res_o == $past(opb_i))) else $error("empty predicate not fill only");

  p_lane0_head_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && any) |=> (res_o[7:0] == $past(head_byte))) else $error("window head misplaced");

endmodule

// File: tb/splice_unit_bench.sv
`timescale 1ns/1ps
module splice_unit_bench;
  localparam int VW = 256;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic [NB-1:0] pred_i = '0;
  logic [VW-1:0] opa_i = '0;
  logic [VW-1:0] opb_i = '0;
  logic [VW-1:0] res_o;
  logic          valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  splice_unit #(.VEC_W(VW)) u_splice_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .pred_i(pred_i), .opa_i(opa_i), .opb_i(opb_i), .res_o(res_o), .valid_o(valid_o)
  );

  // lane-by-lane reference (R1..R6)
  function automatic logic [VW-1:0] ref_splice(input logic [1:0] s, input logic [NB-1:0] p,
                                                input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    int eb = 1 << s;
    int nl = NB / eb;
    int f = -1;
    int l = -1;
    int x = 0;
    for (int ln = 0; ln < nl; ln++) begin
      if (p[ln*eb]) begin
        if (f < 0) f = ln;
        l = ln;
      end
    end
    if (f >= 0) begin
      for (int e = f; e <= l; e++) begin
        for (int j = 0; j < eb; j++) r[(x*eb+j)*8 +: 8] = a[(e*eb+j)*8 +: 8];
        x++;
      end
    end
    for (int e = 0; x < nl; e++) begin
      for (int j = 0; j < eb; j++) r[(x*eb+j)*8 +: 8] = b[(e*eb+j)*8 +: 8];
      x++;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [NB-1:0] lead_bits(input logic [1:0] s);
    logic [NB-1:0] m = '0;
    for (int k = 0; k < NB; k += (1 << s)) m[k] = 1'b1;
    return m;
  endfunction

  task automatic chk_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one operation, then an idle cycle with scrambled inputs
  task automatic one_op(input string req, input logic [1:0] s, input logic [NB-1:0] p);
    logic [VW-1:0] a = rnd_vec();
    logic [VW-1:0] b = rnd_vec();
    logic [VW-1:0] exp = ref_splice(s, p, a, b);
    @(negedge clk);
    start_i = 1'b1; size_i = s; pred_i = p; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk_vec(req, res_o, exp);
    chk_bit("R7 valid after start", valid_o, 1'b1);
    size_i = ~s; pred_i = ~p; opa_i = rnd_vec(); opb_i = rnd_vec();
    @(negedge clk);
    chk_bit("R7 valid drops", valid_o, 1'b0);
    chk_vec("R8 hold while idle", res_o, exp);
  endtask

  initial begin
    void'($urandom(32'h5A1C_E011));
    repeat (3) @(negedge clk);
    chk_bit("R9 valid in reset", valid_o, 1'b0);
    chk_vec("R9 result in reset", res_o, '0);
    rst_ni = 1'b1;

    // directed corners for every size code (R1)
    for (int s = 0; s < 4; s++) begin
      logic [1:0] sz = 2'(s);
      int eb = 1 << s;
      int nl = NB / eb;
      one_op("R6 empty predicate", sz, '0);
      one_op("R3 all active", sz, '1);
      one_op("R3 R5 only lane 0", sz, NB'(1));
      one_op("R3 R5 only top lane", sz, NB'(1) << (NB - eb));
      begin
        logic [NB-1:0] p = '0;
        p[eb] = 1'b1;
        p[(nl-2)*eb] = 1'b1;
        one_op("R4 gap inside window", sz, p);
      end
      if (s > 0) begin
        one_op("R2 non-leading bits ignored", sz, ~lead_bits(sz));
        one_op("R2 mixed leading bits", sz, (NB'(1) << eb) | (NB'(1) << (3*eb)) | NB'(2));
      end
    end

    // back-to-back random starts
    begin
      logic [VW-1:0] exp_q = '0;
      bit have = 1'b0;
      for (int n = 0; n < 400; n++) begin
        logic [1:0] s = 2'($urandom_range(0, 3));
        logic [NB-1:0] p = NB'($urandom);
        logic [VW-1:0] a = rnd_vec();
        logic [VW-1:0] b = rnd_vec();
        case ($urandom_range(0, 3))
          0: p = p & NB'($urandom) & NB'($urandom);
          1: p = p & NB'($urandom);
          default: ;
        endcase
        @(negedge clk);
        if (have) begin
          chk_vec("R3 R4 R5 back-to-back", res_o, exp_q);
          chk_bit("R7 valid back-to-back", valid_o, 1'b1);
        end
        start_i = 1'b1; size_i = s; pred_i = p; opa_i = a; opb_i = b;
        exp_q = ref_splice(s, p, a, b);
        have = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk_vec("R3 R4 R5 last of run", res_o, exp_q);
      @(negedge clk);
      chk_bit("R7 valid ends with run", valid_o, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule